// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank DDR graphics SDRAM. It owns the memory command bus from reset and walks the device through the power-up ritual. First it holds the clock enable low for a settling interval. It then raises the enable under a NOP and clears every bank. Next it programs the extended mode register so that the delay-locked loop is enabled, and writes the mode register with the loop-reset bit set. A second all-bank precharge and a run of auto-refresh commands follow. The last step is a mode write that clears the loop-reset bit and holds the operating burst length, burst type and read latency.

The gaps between commands come from parameters: row precharge time, mode-write recovery and refresh cycle time. The settling interval is the clock rate in MHz times a microsecond count, and a simulation override can shorten it. A lock counter starts with the loop-reset write, and the block does not finish until that counter has also expired. When the sequence completes, `init_done` rises and the block connects the downstream scheduler's command, address, bank and clock-enable inputs straight through to the memory pins.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, and for the first STARTUP_CYC cycles after it is released, `mem_cke` is 0, the bus carries NOP and `init_done` is 0. STARTUP_CYC is SIM_STARTUP_CYC when that parameter is nonzero, and CLK_MHZ*STARTUP_US otherwise.
- R2: In cycle STARTUP_CYC, `mem_cke` rises with a NOP on the bus. It stays high until `init_done`, and no command other than NOP is ever driven while it is low.
- R3: A precharge-all comes one cycle after CKE rises. Precharge-all is {cs_n,ras_n,cas_n,we_n}=0010 with A10=1 and all other address and bank bits 0. T_RP cycles after it comes an extended mode write: encoding 0000, bank 01, A0=0 (loop enabled), A1=DRIVE_SEL[0], A6=DRIVE_SEL[1], and all other address bits 0.
- R4: T_MRD cycles after the extended write comes a mode write on bank 00 with A8=1 (loop reset) and the operating fields of R6.
- R5: T_MRD cycles later comes a second precharge-all. T_RP cycles after that comes the first of N_REF auto-refresh commands (encoding 0001, address and bank 0), and consecutive refreshes are spaced T_RFC cycles apart.
- R6: T_RFC cycles after the last refresh comes the final mode write on bank 00 with A8=0, A7=0, A2..A0=BURST_CODE (001=2, 010=4, 011=8), A3=INTERLEAVE (0 sequential, 1 interleaved), A6..A4=LATENCY_CODE (011 = three cycles) and A12..A9 = 0.
- R7: `init_done` rises in cycle max(final write + T_MRD, loop-reset write + DLL_LOCK_CYC).
- R8: While `init_done` is 0, the scheduler inputs have no effect on the memory pins. While it is 1, every memory pin equals the matching scheduler input in the same cycle.
- R9: `init_done` stays 1 until reset. A reset asserted partway through the sequence returns the block to the state of R1, and the sequence then starts over.
- R10: Every cycle of the sequence that is not a command slot carries NOP, {cs_n,ras_n,cas_n,we_n}=0111. In particular, the cycle after any mode write is a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_cke | input | 1 | Scheduler clock enable request |
| sched_cs_n | input | 1 | Scheduler chip select |
| sched_ras_n | input | 1 | Scheduler row strobe |
| sched_cas_n | input | 1 | Scheduler column strobe |
| sched_we_n | input | 1 | Scheduler write enable |
| sched_addr | input | 13 | Scheduler address |
| sched_ba | input | 2 | Scheduler bank |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Memory chip select |
| mem_ras_n | output | 1 | Memory row strobe |
| mem_cas_n | output | 1 | Memory column strobe |
| mem_we_n | output | 1 | Memory write enable |
| mem_addr | output | 13 | Memory address |
| mem_ba | output | 2 | Memory bank |
| init_done | output | 1 | Sequence complete; bus handed to scheduler |

## Verification
Some properties are checked on every cycle. CKE never drops once it is raised, and no command is driven while it is low. Mode words carry no stray bits, each mode write is followed by a NOP, and any command seen before completion comes from a sequencer command slot. After completion, `init_done` coincides with an expired lock counter, it stays high, and the pins mirror the scheduler inputs. The exact order of commands, their cycle spacing and full address values, and which of the two limits sets the finish time can only be seen in the bench scenarios. The same holds for a reset in the middle of the sequence.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;

  typedef enum logic [3:0] {
    ST_POWER, ST_CKE, ST_PRE1, ST_EMRS, ST_MRS_RST,
    ST_PRE2, ST_REF, ST_MRS_FIN, ST_DONE
  } init_step_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_REF  = 4'b0001;
  localparam logic [3:0] CMD_MODE = 4'b0000;

  function automatic logic [ADDR_W-1:0] mode_word(
    input logic [2:0] burst, input logic ilv,
    input logic [2:0] lat, input logic loop_rst);
    logic [ADDR_W-1:0] w;
    w      = '0;
    w[2:0] = burst;
    w[3]   = ilv;
    w[6:4] = lat;
    w[8]   = loop_rst;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] ext_word(input logic [1:0] drv);
    logic [ADDR_W-1:0] w;
    w    = '0;   // A0 = 0 keeps the loop enabled
    w[1] = drv[0];
    w[6] = drv[1];
    return w;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  output logic lock_ok
);
  localparam int LW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;

  logic [LW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     remain <= LW'(LOCK_CYC - 1);
    else if (armed && remain != '0) remain <= remain - 1'b1;
  end

  assign lock_ok = (remain == '0);
endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int STARTUP_CYC = 20000,
  parameter int T_RP        = 3,
  parameter int T_MRD       = 2,
  parameter int T_RFC       = 14,
  parameter int N_REF       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_ok,
  output init_step_e step,
  output logic       first
);
  localparam int MAXW  = max2(max2(STARTUP_CYC, T_RFC), max2(T_RP, T_MRD));
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam int REF_W = (N_REF > 1) ? $clog2(N_REF) : 1;

  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refs_left;
  logic             step_end;

  function automatic logic [CNT_W-1:0] wait_of(input init_step_e s);
    case (s)
      ST_POWER:                      return CNT_W'(STARTUP_CYC - 1);
      ST_PRE1, ST_PRE2:              return CNT_W'(T_RP - 1);
      ST_EMRS, ST_MRS_RST, ST_MRS_FIN: return CNT_W'(T_MRD - 1);
      ST_REF:                        return CNT_W'(T_RFC - 1);
      default:                       return '0;
    endcase
  endfunction

  function automatic init_step_e next_of(input init_step_e s);
    case (s)
      ST_POWER:   return ST_CKE;
      ST_CKE:     return ST_PRE1;
      ST_PRE1:    return ST_EMRS;
      ST_EMRS:    return ST_MRS_RST;
      ST_MRS_RST: return ST_PRE2;
      ST_PRE2:    return ST_REF;
      ST_REF:     return ST_MRS_FIN;
      default:    return ST_DONE;
    endcase
  endfunction

  assign step_end = (step != ST_DONE) && (cnt == '0) &&
                    ((step != ST_MRS_FIN) || lock_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= ST_POWER;
      cnt       <= wait_of(ST_POWER);
      first     <= 1'b1;
      refs_left <= REF_W'(N_REF - 1);
    end else if (step_end) begin
      first <= 1'b1;
      if (step == ST_REF && refs_left != '0) begin
        refs_left <= refs_left - 1'b1;
        cnt       <= wait_of(ST_REF);
      end else begin
        step <= next_of(step);
        cnt  <= wait_of(next_of(step));
      end
    end else begin
      first <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ddr_init_bus.sv
module ddr_init_bus
  import ddr_init_pkg::*;
#(
  parameter logic [2:0] BURST_CODE   = 3'b011,
  parameter logic       INTERLEAVE   = 1'b0,
  parameter logic [2:0] LATENCY_CODE = 3'b011,
  parameter logic [1:0] DRIVE_SEL    = 2'b00
) (
  input  init_step_e        step,
  input  logic              issue,
  input  logic              sched_cke,
  input  logic [3:0]        sched_cmd,
  input  logic [ADDR_W-1:0] sched_addr,
  input  logic [BA_W-1:0]   sched_ba,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  always_comb begin
    cke  = (step != ST_POWER);
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    if (step == ST_DONE) begin
      cke  = sched_cke;
      cmd  = sched_cmd;
      addr = sched_addr;
      ba   = sched_ba;
    end else if (issue) begin
      case (step)
        ST_PRE1, ST_PRE2: begin
          cmd      = CMD_PRE;
          addr[10] = 1'b1;
        end
        ST_EMRS: begin
          cmd  = CMD_MODE;
          ba   = 2'b01;
          addr = ext_word(DRIVE_SEL);
        end
        ST_MRS_RST: begin
          cmd  = CMD_MODE;
          addr = mode_word(BURST_CODE, INTERLEAVE, LATENCY_CODE, 1'b1);
        end
        ST_REF:     cmd = CMD_REF;
        ST_MRS_FIN: begin
          cmd  = CMD_MODE;
          addr = mode_word(BURST_CODE, INTERLEAVE, LATENCY_CODE, 1'b0);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int         CLK_MHZ         = 100,
  parameter int         STARTUP_US      = 200,
  parameter int         SIM_STARTUP_CYC = 0,
  parameter int         DLL_LOCK_CYC    = 200,
  parameter int         T_RP            = 3,
  parameter int         T_MRD           = 2,
  parameter int         T_RFC           = 14,
  parameter int         N_REF           = 2,
  parameter logic [2:0] BURST_CODE      = 3'b011,
  parameter logic       INTERLEAVE      = 1'b0,
  parameter logic [2:0] LATENCY_CODE    = 3'b011,
  parameter logic [1:0] DRIVE_SEL       = 2'b00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sched_cke,
  input  logic        sched_cs_n,
  input  logic        sched_ras_n,
  input  logic        sched_cas_n,
  input  logic        sched_we_n,
  input  logic [12:0] sched_addr,
  input  logic [1:0]  sched_ba,
  output logic        mem_cke,
  output logic        mem_cs_n,
  output logic        mem_ras_n,
  output logic        mem_cas_n,
  output logic        mem_we_n,
  output logic [12:0] mem_addr,
  output logic [1:0]  mem_ba,
  output logic        init_done
);
  localparam int STARTUP_CYC = (SIM_STARTUP_CYC > 0) ? SIM_STARTUP_CYC
                                                     : CLK_MHZ * STARTUP_US;

  init_step_e step;
  logic       cmd_issue;
  logic       lock_ok;
  logic       lock_armed;
  logic [3:0] bus_cmd;

  assign lock_armed = step inside {ST_MRS_RST, ST_PRE2, ST_REF, ST_MRS_FIN, ST_DONE};

  ddr_init_lock #(.LOCK_CYC(DLL_LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .armed(lock_armed), .lock_ok(lock_ok)
  );

  ddr_init_fsm #(
    .STARTUP_CYC(STARTUP_CYC), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RFC(T_RFC), .N_REF(N_REF)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .lock_ok(lock_ok), .step(step), .first(cmd_issue)
  );

  ddr_init_bus #(
    .BURST_CODE(BURST_CODE), .INTERLEAVE(INTERLEAVE),
    .LATENCY_CODE(LATENCY_CODE), .DRIVE_SEL(DRIVE_SEL)
  ) u_bus (
    .step(step), .issue(cmd_issue), .sched_cke(sched_cke),
    .sched_cmd({sched_cs_n, sched_ras_n, sched_cas_n, sched_we_n}),
    .sched_addr(sched_addr), .sched_ba(sched_ba),
    .cke(mem_cke), .cmd(bus_cmd), .addr(mem_addr), .ba(mem_ba)
  );

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = bus_cmd;
  assign init_done = (step == ST_DONE);
endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sched_cke,
  input logic        sched_cs_n,
  input logic        sched_ras_n,
  input logic        sched_cas_n,
  input logic        sched_we_n,
  input logic [12:0] sched_addr,
  input logic [1:0]  sched_ba,
  input logic        mem_cke,
  input logic        mem_cs_n,
  input logic        mem_ras_n,
  input logic        mem_cas_n,
  input logic        mem_we_n,
  input logic [12:0] mem_addr,
  input logic [1:0]  mem_ba,
  input logic        init_done,
  input logic        lock_ok,
  input logic        cmd_issue
);
  logic [3:0] cmd;
  assign cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

  a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && $past(mem_cke)) |-> mem_cke);

  a_r2_no_cmd_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd != 4'b0111) |-> mem_cke);

  a_r3_ext_word_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == 4'b0000 && mem_ba == 2'b01) |-> ((mem_addr & ~13'h0042) == 13'h0));

  a_r6_mode_word_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == 4'b0000 && mem_ba == 2'b00) |-> (!mem_addr[7] && mem_addr[12:9] == 4'h0));

  a_r10_nop_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd == 4'b0000) |=> (cmd == 4'b0111));

  a_r5_cmd_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd != 4'b0111) |-> cmd_issue);

  a_r7_done_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> lock_ok);

  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == {sched_cs_n, sched_ras_n, sched_cas_n, sched_we_n} &&
                   mem_cke == sched_cke && mem_addr == sched_addr && mem_ba == sched_ba));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

bind ddr_init_seq ddr_init_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sched_cke(sched_cke), .sched_cs_n(sched_cs_n),
  .sched_ras_n(sched_ras_n), .sched_cas_n(sched_cas_n), .sched_we_n(sched_we_n),
  .sched_addr(sched_addr), .sched_ba(sched_ba), .mem_cke(mem_cke),
  .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
  .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_ba(mem_ba),
  .init_done(init_done), .lock_ok(lock_ok), .cmd_issue(cmd_issue)
);

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;
  localparam int S    = 20;
  localparam int TRP  = 3;
  localparam int TMRD = 2;
  localparam int TRFC = 14;
  localparam int LOCK0 = 200;
  localparam int LOCK1 = 20;

  // expected command cycles, counted from the first cycle after reset release
  localparam int C_PRE1 = S + 1;
  localparam int C_EMRS = C_PRE1 + TRP;
  localparam int C_MRS  = C_EMRS + TMRD;
  localparam int C_PRE2 = C_MRS + TMRD;
  localparam int C_REF1 = C_PRE2 + TRP;
  localparam int C_REF2 = C_REF1 + TRFC;
  localparam int C_FIN  = C_REF2 + TRFC;
  localparam int D0 = (C_FIN + TMRD > C_MRS + LOCK0) ? C_FIN + TMRD : C_MRS + LOCK0;
  localparam int D1 = (C_FIN + TMRD > C_MRS + LOCK1) ? C_FIN + TMRD : C_MRS + LOCK1;

  // {cycle[15:0], cs_n ras_n cas_n we_n, ba[1:0], addr[12:0]}
  // burst 8 (011), interleaved, latency 011, drive A6=1 A1=0
  localparam logic [34:0] EXP [7] = '{
    {16'(C_PRE1), 4'b0010, 2'b00, 13'h0400},
    {16'(C_EMRS), 4'b0000, 2'b01, 13'h0040},
    {16'(C_MRS),  4'b0000, 2'b00, 13'h013B},
    {16'(C_PRE2), 4'b0010, 2'b00, 13'h0400},
    {16'(C_REF1), 4'b0001, 2'b00, 13'h0000},
    {16'(C_REF2), 4'b0001, 2'b00, 13'h0000},
    {16'(C_FIN),  4'b0000, 2'b00, 13'h003B}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_cke, s_cs, s_ras, s_cas, s_we;
  logic [12:0] s_addr;
  logic [1:0]  s_ba;
  logic m0_cke, m0_cs, m0_ras, m0_cas, m0_we, done0;
  logic [12:0] m0_addr;
  logic [1:0]  m0_ba;
  logic m1_cke, m1_cs, m1_ras, m1_cas, m1_we, done1;
  logic [12:0] m1_addr;
  logic [1:0]  m1_ba;

  int n_chk = 0;
  int n_err = 0;
  int wd = 0;

  always #5 clk = ~clk;

  ddr_init_seq #(.SIM_STARTUP_CYC(S), .DLL_LOCK_CYC(LOCK0), .T_RP(TRP), .T_MRD(TMRD),
    .T_RFC(TRFC), .N_REF(2), .BURST_CODE(3'b011), .INTERLEAVE(1'b1),
    .LATENCY_CODE(3'b011), .DRIVE_SEL(2'b10)) u0 (
    .clk(clk), .rst_n(rst_n), .sched_cke(s_cke), .sched_cs_n(s_cs),
    .sched_ras_n(s_ras), .sched_cas_n(s_cas), .sched_we_n(s_we),
    .sched_addr(s_addr), .sched_ba(s_ba), .mem_cke(m0_cke), .mem_cs_n(m0_cs),
    .mem_ras_n(m0_ras), .mem_cas_n(m0_cas), .mem_we_n(m0_we),
    .mem_addr(m0_addr), .mem_ba(m0_ba), .init_done(done0));

  ddr_init_seq #(.SIM_STARTUP_CYC(S), .DLL_LOCK_CYC(LOCK1), .T_RP(TRP), .T_MRD(TMRD),
    .T_RFC(TRFC), .N_REF(2), .BURST_CODE(3'b011), .INTERLEAVE(1'b1),
    .LATENCY_CODE(3'b011), .DRIVE_SEL(2'b10)) u1 (
    .clk(clk), .rst_n(rst_n), .sched_cke(s_cke), .sched_cs_n(s_cs),
    .sched_ras_n(s_ras), .sched_cas_n(s_cas), .sched_we_n(s_we),
    .sched_addr(s_addr), .sched_ba(s_ba), .mem_cke(m1_cke), .mem_cs_n(m1_cs),
    .mem_ras_n(m1_ras), .mem_cas_n(m1_cas), .mem_we_n(m1_we),
    .mem_addr(m1_addr), .mem_ba(m1_ba), .init_done(done1));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 1:    return "R3";
      2:       return "R4";
      3, 4, 5: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [34:0] rec [16];
    int rec_n;
    int cke_bad;
    int nop_bad;
    int d0_cyc;
    int d1_cyc;
    int first_cmd;
    logic [3:0] c0;

    rec_n = 0; cke_bad = 0; nop_bad = 0; d0_cyc = -1; d1_cyc = -1;
    // scheduler pattern that the sequencer never produces: ignored until done (R8)
    s_cke = 1'b0; {s_cs, s_ras, s_cas, s_we} = 4'b0101; s_addr = 13'h1555; s_ba = 2'b11;
    repeat (3) @(negedge clk);
    #1;
    // R1: state while reset is held
    check(m0_cke == 1'b0, "R1 cke in reset", 64'(m0_cke), 64'h0);
    check(done0 == 1'b0, "R1 done in reset", 64'(done0), 64'h0);
    check({m0_cs, m0_ras, m0_cas, m0_we} == 4'b0111, "R1 nop in reset",
          64'({m0_cs, m0_ras, m0_cas, m0_we}), 64'h7);

    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int cyc = 0; cyc < 260; cyc++) begin
      c0 = {m0_cs, m0_ras, m0_cas, m0_we};
      if (!done0) begin
        if (m0_cke != (cyc >= S)) cke_bad++;              // R1, R2
        if (c0 != 4'b0111) begin
          if (rec_n < 16) rec[rec_n] = {16'(cyc), c0, m0_ba, m0_addr};
          rec_n++;
        end
      end else if (d0_cyc < 0) d0_cyc = cyc;
      if (done1 && d1_cyc < 0) d1_cyc = cyc;
      @(negedge clk);
      #1;
    end

    check(cke_bad == 0, "R2 cke timeline", 64'(cke_bad), 64'h0);
    check(rec_n == 7, "R10 command count, rest NOP", 64'(rec_n), 64'h7);
    // table walk: command, bank, address and cycle of every sequence step
    for (int i = 0; i < 7; i++)
      check(rec[i] == EXP[i], tag_of(i), 64'(rec[i]), 64'(EXP[i]));
    check(d0_cyc == D0, "R7 done set by lock", 64'(d0_cyc), 64'(D0));
    check(d1_cyc == D1, "R7 done set by final write", 64'(d1_cyc), 64'(D1));

    // R8: pass-through after completion, two patterns
    s_cke = 1'b1; {s_cs, s_ras, s_cas, s_we} = 4'b0100; s_addr = 13'h0ACE; s_ba = 2'b10;
    #1;
    check({m0_cke, m0_cs, m0_ras, m0_cas, m0_we, m0_ba, m0_addr} ==
          {1'b1, 4'b0100, 2'b10, 13'h0ACE}, "R8 pass-through A",
          64'({m0_cke, m0_cs, m0_ras, m0_cas, m0_we, m0_ba, m0_addr}),
          64'({1'b1, 4'b0100, 2'b10, 13'h0ACE}));
    @(negedge clk);
    s_cke = 1'b0; {s_cs, s_ras, s_cas, s_we} = 4'b1111; s_addr = 13'h1F0F; s_ba = 2'b01;
    #1;
    check({m0_cke, m0_cs, m0_ras, m0_cas, m0_we, m0_ba, m0_addr} ==
          {1'b0, 4'b1111, 2'b01, 13'h1F0F}, "R8 pass-through B",
          64'({m0_cke, m0_cs, m0_ras, m0_cas, m0_we, m0_ba, m0_addr}),
          64'({1'b0, 4'b1111, 2'b01, 13'h1F0F}));

    repeat (20) @(negedge clk);
    #1;
    check(done0 == 1'b1, "R9 done sticky", 64'(done0), 64'h1);

    // R9: reset partway through the sequence, then restart
    s_cke = 1'b0; {s_cs, s_ras, s_cas, s_we} = 4'b0101;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (C_PRE2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(m0_cke == 1'b0 && done0 == 1'b0, "R9 mid reset back to R1",
          64'({m0_cke, done0}), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    first_cmd = -1;
    for (int cyc = 0; cyc < S + 5; cyc++) begin
      if (first_cmd < 0 && {m0_cs, m0_ras, m0_cas, m0_we} != 4'b0111) first_cmd = cyc;
      @(negedge clk);
      #1;
    end
    check(first_cmd == C_PRE1, "R9 restart first command", 64'(first_cmd), 64'(C_PRE1));

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule